// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer for a system controller. Software reaches it through a small byte-addressed register file with separate read and write strobes. A down-counter loses one step on every slow tick. A prescaler on the core clock produces that tick. In a real system one tick stands for 0.6 seconds. Software restarts the count by writing the reload register. A halt bit in the control register freezes or resumes the count. Software can read the current count at any time.

When the count runs out the first time, the block raises a first-timeout flag and starts again from the programmed initial value. If the count runs out again while that flag is still set, the block raises the second-timeout and boot flags. It then requests a system reset for one clock, unless the `no_reboot` input is high. All status flags are cleared by writing a one to them. The initial value must be at least four: smaller values are refused and the old value is kept.

Register reads carry no back-pressure. A read strobe is always accepted. Its data appears one cycle later, marked by `rd_valid`. A write strobe takes effect on the clock edge where it is sampled.

Top module: `two_stage_wdt`

## Requirements
- R1: After reset, the halt bit is 1 and all status flags are 0. The initial value and the count both equal the parameter `INIT_DEFAULT`, and `rst_req` is 0.
- R2: While the halt bit is 0, the count drops by one every `PRESCALE` clocks. While the halt bit is 1, the count holds and the prescaler is cleared. Reading byte offset 0x00 returns the live count in bits 9:0, with the upper bits reading 0.
- R3: Any write to offset 0x00 loads the count with the current initial value, whatever the data.
- R4: The initial value lives in bits 9:0 of offset 0x12. A write with bits 9:0 below 4 is ignored. Bits 15:10 always read 0, and writes to them have no effect.
- R5: Bit 11 of offset 0x08 is the halt bit and reads back as written. All other bits of that register read 0.
- R6: An expiry is a tick that arrives while the count is 0. An expiry with the first-timeout flag (offset 0x04, bit 3) clear sets that flag and reloads the count, with no reset request.
- R7: An expiry with the first-timeout flag already set does three things. It sets the second-timeout flag (offset 0x06, bit 1) and the boot flag (offset 0x06, bit 2). It also drives `rst_req` high for exactly one clock.
- R8: While `no_reboot` is high, an expiry never produces `rst_req`, but the flags still update as in R6 and R7.
- R9: Writing 1 to a status flag bit clears that flag. Writing 0 to it leaves the flag unchanged.
- R10: A read strobe returns data and `rd_valid` one clock later. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| no_reboot | input | 1 | Blocks the reset request when high |
| rst_req | output | 1 | One-clock system reset request |

## Verification
The hardest situation to reach from the ports is the pair of second expiries that differ only in one thing. In the first, the first-timeout flag is cleared between the two expiries, so the block must re-arm and must not escalate. In the second, the flag is left set, so the block must escalate. The bench shortens the prescaler to a few clocks and programs a small initial value. It then releases the halt bit and times its register writes between the computed expiry points, so that the status write-clear lands between the first and second expiry. The live count is checked deterministically by halting the counter at a chosen distance from release, away from any tick boundary.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  // Register byte offsets (decoded by software)
  localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT1 = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STAT2 = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_INIT  = 5'h12;

  // Bit positions
  localparam int HALT_BIT   = 11;
  localparam int FIRST_BIT  = 3;
  localparam int SECOND_BIT = 1;
  localparam int BOOT_BIT   = 2;

  localparam int MIN_INIT = 4;

  typedef struct packed {
    logic first;
    logic second;
    logic boot;
  } wdt_flags_t;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int PRESCALE = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] TERM = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;

  assign tick = run && (pre_q == TERM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pre_q <= '0;
    else if (!run || restart)   pre_q <= '0;
    else if (pre_q == TERM)     pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= TERM);
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
  parameter int          CNT_W     = 10,
  parameter logic [CNT_W-1:0] RESET_VAL = 10'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] init_val,
  input  logic             load,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  assign expire = tick && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= RESET_VAL;
    else if (load)       count <= init_val;
    else if (tick) begin
      if (count == '0)   count <= init_val;
      else               count <= count - 1'b1;
    end
  end

  assert_expire_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count == $past(init_val));
endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       no_reboot,
  input  logic       clr_first,
  input  logic       clr_second,
  input  logic       clr_boot,
  output wdt_flags_t flags,
  output logic       rst_req
);
  logic escalate;
  assign escalate = expire && flags.first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= escalate && !no_reboot;
      // set has priority over a same-cycle clear
      if (expire && !flags.first) flags.first <= 1'b1;
      else if (clr_first)         flags.first <= 1'b0;
      if (escalate)               flags.second <= 1'b1;
      else if (clr_second)        flags.second <= 1'b0;
      if (escalate)               flags.boot <= 1'b1;
      else if (clr_boot)          flags.boot <= 1'b0;
    end
  end

  assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_rst_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (flags.second && flags.boot));
  assert_rst_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(no_reboot));
endmodule

// File: rtl/two_stage_wdt.sv
module two_stage_wdt
  import wdt_pkg::*;
#(
  parameter int PRESCALE     = 60000,
  parameter int CNT_W        = 10,
  parameter int INIT_DEFAULT = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              no_reboot,
  output logic              rst_req
);
  localparam logic [CNT_W-1:0] INIT_RST = CNT_W'(INIT_DEFAULT);

  logic             halt_q;
  logic [CNT_W-1:0] init_q;
  logic [CNT_W-1:0] count;
  logic             tick, expire, reload;
  wdt_flags_t       flags;
  logic [DATA_W-1:0] rd_mux;

  assign reload = wr_en && (addr == OFS_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      init_q <= INIT_RST;
    end else if (wr_en) begin
      if (addr == OFS_CTRL) halt_q <= wr_data[HALT_BIT];
      if (addr == OFS_INIT && wr_data[CNT_W-1:0] >= CNT_W'(MIN_INIT))
        init_q <= wr_data[CNT_W-1:0];
    end
  end

  wdt_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(!halt_q), .restart(reload), .tick(tick)
  );

  wdt_down_counter #(.CNT_W(CNT_W), .RESET_VAL(INIT_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .init_val(init_q), .load(reload),
    .tick(tick), .count(count), .expire(expire)
  );

  wdt_status u_stat (
    .clk(clk), .rst_n(rst_n), .expire(expire), .no_reboot(no_reboot),
    .clr_first (wr_en && addr == OFS_STAT1 && wr_data[FIRST_BIT]),
    .clr_second(wr_en && addr == OFS_STAT2 && wr_data[SECOND_BIT]),
    .clr_boot  (wr_en && addr == OFS_STAT2 && wr_data[BOOT_BIT]),
    .flags(flags), .rst_req(rst_req)
  );

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_COUNT: rd_mux[CNT_W-1:0] = count;
      OFS_INIT:  rd_mux[CNT_W-1:0] = init_q;
      OFS_CTRL:  rd_mux[HALT_BIT]  = halt_q;
      OFS_STAT1: rd_mux[FIRST_BIT] = flags.first;
      OFS_STAT2: begin
        rd_mux[SECOND_BIT] = flags.second;
        rd_mux[BOOT_BIT]   = flags.boot;
      end
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? rd_mux : '0;
    end
  end

  assert_init_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    init_q >= CNT_W'(MIN_INIT));
  assert_halt_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !reload) |=> $stable(count));
  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

// File: tb/tb_two_stage_wdt.sv
module tb_two_stage_wdt;
  localparam int PRESCALE = 4;
  localparam int INIT_DEF = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        no_reboot = 1'b0;
  logic        rst_req;

  int n_checks = 0;
  int n_fail = 0;
  int rst_cnt = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  two_stage_wdt #(.PRESCALE(PRESCALE), .CNT_W(10), .INIT_DEFAULT(INIT_DEF)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .no_reboot(no_reboot), .rst_req(rst_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compare read results against the scoreboard
  always @(negedge clk) begin
    if (rst_req) rst_cnt++;
    if (rd_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected rd_valid", 1, 0);
      else check(tag_q.pop_front(), int'(rd_data), int'(exp_q.pop_front()));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (exp_q.size() != 0) check("R10 reads left unanswered", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 rst_req after reset", int'(rst_req), 0);
    rd(5'h08, 16'h0800, "R1 halt set after reset");
    rd(5'h04, 16'h0000, "R1 first flag clear");
    rd(5'h06, 16'h0000, "R1 second/boot clear");
    rd(5'h12, 16'(INIT_DEF), "R1 init default");
    rd(5'h00, 16'(INIT_DEF), "R1 count default");
    idle(50);
    rd(5'h00, 16'(INIT_DEF), "R2 halted count frozen");
    rd(5'h0C, 16'h0000, "R10 unmapped reads zero");

    // R4 initial value rules
    wr(5'h12, 16'hFC07);
    rd(5'h12, 16'h0007, "R4 upper bits ignored");
    wr(5'h12, 16'h0003);
    rd(5'h12, 16'h0007, "R4 value 3 rejected");
    wr(5'h12, 16'h0000);
    rd(5'h12, 16'h0007, "R4 value 0 rejected");
    // R5 control readback
    wr(5'h08, 16'hFFFF);
    rd(5'h08, 16'h0800, "R5 only halt bit reads");

    // R2 live count: init 100, run 18 edges -> 4 ticks
    wr(5'h12, 16'd100);
    wr(5'h00, 16'h0000);
    rd(5'h00, 16'd100, "R3 reload to init");
    wr(5'h08, 16'h0000);
    idle(17);
    wr(5'h08, 16'h0800);
    rd(5'h00, 16'd96, "R2 live count after 4 ticks");

    // R3 keepalive prevents expiry
    wr(5'h12, 16'd20);
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0000);
    rd(5'h08, 16'h0000, "R5 halt cleared");
    for (int i = 0; i < 5; i++) begin
      idle(40);
      wr(5'h00, 16'h1234);
    end
    wr(5'h08, 16'h0800);
    rd(5'h04, 16'h0000, "R3 reloads kept flag clear");

    // R6/R7 two-stage expiry with init 7 (expiries at 32, 64 edges)
    wr(5'h12, 16'd7);
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0000);
    idle(38);
    rd(5'h04, 16'h0008, "R6 first timeout set");
    rd(5'h06, 16'h0000, "R6 no second timeout yet");
    check("R6 no reset on first expiry", rst_cnt, 0);
    idle(26);
    rd(5'h06, 16'h0006, "R7 second and boot set");
    wr(5'h08, 16'h0800);
    check("R7 one reset pulse", rst_cnt, 1);

    // R9 write-one-to-clear
    wr(5'h04, 16'h0000);
    rd(5'h04, 16'h0008, "R9 writing 0 keeps flag");
    wr(5'h04, 16'hFFF7);
    rd(5'h04, 16'h0008, "R9 other ones keep flag");
    wr(5'h06, 16'h0002);
    rd(5'h06, 16'h0004, "R9 clear second only");
    wr(5'h06, 16'h0004);
    wr(5'h04, 16'h0008);
    rd(5'h04, 16'h0000, "R9 first cleared");
    rd(5'h06, 16'h0000, "R9 boot cleared");

    // R6 re-arm when first flag cleared between expiries
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0000);
    idle(37);
    wr(5'h04, 16'h0008);
    idle(34);
    wr(5'h08, 16'h0800);
    rd(5'h04, 16'h0008, "R6 re-armed first flag");
    rd(5'h06, 16'h0000, "R6 no escalation after clear");
    check("R6 no reset after re-arm", rst_cnt, 1);

    // R8 no_reboot gate
    wr(5'h04, 16'h0008);
    no_reboot = 1'b1;
    wr(5'h00, 16'h0000);
    wr(5'h08, 16'h0000);
    idle(68);
    wr(5'h08, 16'h0800);
    rd(5'h06, 16'h0006, "R8 flags still escalate");
    rd(5'h04, 16'h0008, "R8 first flag set");
    check("R8 reset blocked", rst_cnt, 1);
    no_reboot = 1'b0;

    idle(4);
    finish_run();
  end
endmodule